// File: doc/BRIEF.md
# Bit-Band Alias Address Translator

This unit sits between a simple word bus master and a word-wide memory. Two primary regions, at 0x20000000 and 0x40000000, each have a matching alias region at the primary base with bit 25 also set. Every bit of a primary region has its own 32-bit word in its alias region. Touching one alias word is therefore the same as touching one bit of a primary word. The alias word for bit `b` of the word at byte offset `o` sits at `(base & 0xF0000000) | 0x02000000 | ((o & 0x000FFFFF) << 5) | (b << 2)`.

An alias store becomes an internal read-modify-write of the target word. Only the chosen bit changes, and the bus stays not-ready until the write-back has been issued, so no other access can slip in between the read and the write. An alias load returns the chosen bit as a 0 or 1 word. Every other address, including the primary regions themselves, goes to the memory port unchanged.

The master raises `up_req` with `up_we`, `up_addr` and `up_wdata`, and holds them steady until it sees the one-cycle `up_ready` pulse. For a load, `up_rdata` is valid in that same cycle. The memory port is synchronous: read data appears on `mem_rdata` one cycle after a read strobe.

Top module: `bb_alias_xlate`

## Requirements
- R1: An address is an alias address only if its top nibble is 0x2 or 0x4, bit 25 is 1 and bits 27:26 are 0. Any other address, for example 0x24000000 or 0x21000000, is treated as a plain address.
- R2: For an alias address `a`, the target word address is `(a & 0xF0000000) | ((a >> 5) & 0x000FFFFC)` and the bit index is `a[6:2]`. The highest alias word 0x43FFFFFC maps to bit 31 of 0x400FFFFC.
- R3: An alias store sets the target bit when the write data is 1 and clears it when the write data is 0. All other bits of the target word keep their values.
- R4: An alias store looks only at bit 0 of `up_wdata`. Write data 0xFFFFFFFE clears the bit and 0xFFFFFFFF sets it.
- R5: An alias load returns 0x00000001 when the target bit is 1 and 0x00000000 when it is 0, and issues no memory write.
- R6: An alias store issues exactly one memory read followed by exactly one memory write to the same word address, and `up_ready` rises only after that write has been issued.
- R7: A plain access is forwarded with its address unchanged. A plain store writes the full 32-bit data with one memory write, and a plain load returns the full stored word.
- R8: After reset `up_ready` and `mem_en` are 0. Each request produces exactly one `up_ready` pulse, one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_req | input | 1 | Bus request, held until up_ready |
| up_we | input | 1 | 1 = store, 0 = load |
| up_addr | input | 32 | Byte address of the word access |
| up_wdata | input | 32 | Store data |
| up_rdata | output | 32 | Load data, valid while up_ready is 1 |
| up_ready | output | 1 | One-cycle completion pulse |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after a read strobe |

## Verification
On every cycle the assertions check the following:
- alias loads return a word whose upper 31 bits are zero;
- the memory write of an alias store differs from the word read just before it in at most one bit, and goes to the address given by the reverse mapping;
- plain accesses reach memory with an untouched address;
- a load never writes memory;
- an alias store finishes only after its write-back;
- `up_ready` is never high for two cycles in a row.

Other properties need the bench's scenarios, because the assertions do not model memory contents:
- that the correct bit is set or cleared;
- that write data bits other than bit 0 are ignored;
- that neighbouring bits survive;
- that the highest alias word maps to bit 31 of the last primary word.

// File: rtl/bb_pkg.sv
package bb_pkg;

  // Controller sequence states
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_CAP  = 2'd2,
    ST_FIN  = 2'd3
  } bb_state_e;

  // Kind of access accepted in the idle state
  typedef enum logic [1:0] {
    K_PLAIN    = 2'd0,
    K_ALIAS_RD = 2'd1,
    K_ALIAS_WR = 2'd2
  } bb_kind_e;

endpackage

// File: rtl/bb_decode.sv
// Alias region decode and reverse address mapping (R1, R2)
module bb_decode #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned TOP_W     = 4,
  parameter int unsigned ALIAS_BIT = 25,
  parameter int unsigned SPAN_W    = 20,
  parameter logic [ADDR_W-1:0] REGION_A = 32'h2000_0000,
  parameter logic [ADDR_W-1:0] REGION_B = 32'h4000_0000,
  localparam int unsigned IDX_W    = $clog2(DATA_W),
  localparam int unsigned WORD_LSB = $clog2(DATA_W / 8)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              alias_hit,
  output logic [ADDR_W-1:0] word_addr,
  output logic [IDX_W-1:0]  bit_idx
);

  localparam int unsigned TOP_LSB = ADDR_W - TOP_W;
  localparam int unsigned N_REG   = 2;
  localparam logic [ADDR_W-1:0] TOP_MASK =
    {{TOP_W{1'b1}}, {(ADDR_W - TOP_W){1'b0}}};
  localparam logic [ADDR_W-1:0] SPAN_MASK =
    {{(ADDR_W - SPAN_W){1'b0}}, {(SPAN_W - WORD_LSB){1'b1}}, {WORD_LSB{1'b0}}};

  logic [N_REG-1:0] region_hit;

  for (genvar g = 0; g < N_REG; g++) begin : g_region
    localparam logic [ADDR_W-1:0] BASE = (g == 0) ? REGION_A : REGION_B;
    assign region_hit[g] = (addr[ADDR_W-1:TOP_LSB] == BASE[ADDR_W-1:TOP_LSB]);
  end

  assign alias_hit = (|region_hit) && addr[ALIAS_BIT] &&
                     (addr[TOP_LSB-1:ALIAS_BIT+1] == '0);
  assign word_addr = (addr & TOP_MASK) | ((addr >> IDX_W) & SPAN_MASK);
  assign bit_idx   = addr[WORD_LSB +: IDX_W];

endmodule

// File: rtl/bb_bitop.sv
// Single-bit insert and extract on a data word (R3, R5)
module bb_bitop #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] word_in,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic              set_val,
  output logic [DATA_W-1:0] word_out,
  output logic              bit_out
);

  always_comb begin
    word_out          = word_in;
    word_out[bit_idx] = set_val;
    bit_out           = word_in[bit_idx];
  end

endmodule

// File: rtl/bb_ctrl.sv
// Access sequencer with registered bus and memory outputs (R6, R7, R8)
module bb_ctrl #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              up_req,
  input  logic              up_we,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic [DATA_W-1:0] up_wdata,
  input  logic              alias_hit,
  input  logic [ADDR_W-1:0] word_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [DATA_W-1:0] merged,
  input  logic              bit_out,
  output logic [DATA_W-1:0] up_rdata,
  output logic              up_ready,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  import bb_pkg::*;

  bb_state_e state;
  bb_kind_e  kind;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      kind      <= K_PLAIN;
      up_ready  <= 1'b0;
      up_rdata  <= '0;
      mem_en    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      up_ready <= 1'b0;
      mem_en   <= 1'b0;
      mem_we   <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (up_req && !up_ready) begin
            mem_en   <= 1'b1;
            mem_addr <= alias_hit ? word_addr : up_addr;
            if (!alias_hit) begin
              kind <= K_PLAIN;
              if (up_we) begin
                mem_we    <= 1'b1;
                mem_wdata <= up_wdata;
                state     <= ST_FIN;
              end else begin
                state <= ST_WAIT;
              end
            end else begin
              kind  <= up_we ? K_ALIAS_WR : K_ALIAS_RD;
              state <= ST_WAIT;
            end
          end
        end
        ST_WAIT: state <= ST_CAP;
        ST_CAP: begin
          if (kind == K_ALIAS_WR) begin
            mem_en    <= 1'b1;
            mem_we    <= 1'b1;
            mem_wdata <= merged;
            state     <= ST_FIN;
          end else begin
            up_ready <= 1'b1;
            up_rdata <= (kind == K_ALIAS_RD) ? {{(DATA_W-1){1'b0}}, bit_out} : mem_rdata;
            state    <= ST_IDLE;
          end
        end
        ST_FIN: begin
          up_ready <= 1'b1;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bb_alias_xlate.sv
// Top: bit-band alias translator between a word bus and a word memory
module bb_alias_xlate #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned TOP_W     = 4,
  parameter int unsigned ALIAS_BIT = 25,
  parameter int unsigned SPAN_W    = 20,
  parameter logic [ADDR_W-1:0] REGION_A = 32'h2000_0000,
  parameter logic [ADDR_W-1:0] REGION_B = 32'h4000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              up_req,
  input  logic              up_we,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic [DATA_W-1:0] up_wdata,
  output logic [DATA_W-1:0] up_rdata,
  output logic              up_ready,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);

  localparam int unsigned IDX_W = $clog2(DATA_W);

  logic              alias_hit;
  logic [ADDR_W-1:0] word_addr;
  logic [IDX_W-1:0]  bit_idx;
  logic [DATA_W-1:0] merged;
  logic              bit_out;

  bb_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TOP_W(TOP_W), .ALIAS_BIT(ALIAS_BIT),
    .SPAN_W(SPAN_W), .REGION_A(REGION_A), .REGION_B(REGION_B)
  ) u_decode (
    .addr      (up_addr),
    .alias_hit (alias_hit),
    .word_addr (word_addr),
    .bit_idx   (bit_idx)
  );

  // Only bit 0 of the store data is used (R4)
  bb_bitop #(.DATA_W(DATA_W)) u_bitop (
    .word_in  (mem_rdata),
    .bit_idx  (bit_idx),
    .set_val  (up_wdata[0]),
    .word_out (merged),
    .bit_out  (bit_out)
  );

  bb_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .up_req    (up_req),
    .up_we     (up_we),
    .up_addr   (up_addr),
    .up_wdata  (up_wdata),
    .alias_hit (alias_hit),
    .word_addr (word_addr),
    .mem_rdata (mem_rdata),
    .merged    (merged),
    .bit_out   (bit_out),
    .up_rdata  (up_rdata),
    .up_ready  (up_ready),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

endmodule

// File: rtl/bb_alias_xlate_chk.sv
// Property checker attached to the translator
module bb_alias_xlate_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              up_req,
  input logic              up_we,
  input logic [ADDR_W-1:0] up_addr,
  input logic [DATA_W-1:0] up_wdata,
  input logic [DATA_W-1:0] up_rdata,
  input logic              up_ready,
  input logic              mem_en,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [DATA_W-1:0] mem_rdata
);

  logic              is_alias;
  logic [ADDR_W-1:0] tgt;
  logic              rd_pend;
  logic [DATA_W-1:0] last_rd;
  logic              unused_ok;

  assign unused_ok = ^up_wdata;
  assign is_alias  = ((up_addr[31:28] == 4'h2) || (up_addr[31:28] == 4'h4)) &&
                     (up_addr[27:25] == 3'b001);
  assign tgt       = {up_addr[31:28], 8'h00, up_addr[24:7], 2'b00};

  // Word most recently returned by the memory
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend <= 1'b0;
      last_rd <= '0;
    end else begin
      rd_pend <= mem_en && !mem_we;
      if (rd_pend) last_rd <= mem_rdata;
    end
  end

  AST_ALIAS_RD_BOOL: assert property (@(posedge clk) disable iff (rst)
    up_ready && up_req && !up_we && is_alias |-> up_rdata[DATA_W-1:1] == '0); // R5

  AST_ALIAS_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
    mem_en && mem_we && up_req && up_we && is_alias |->
      $countones(mem_wdata ^ last_rd) <= 1); // R3

  AST_ALIAS_TARGET: assert property (@(posedge clk) disable iff (rst)
    mem_en && up_req && is_alias |-> mem_addr == tgt); // R2

  AST_PLAIN_ADDR: assert property (@(posedge clk) disable iff (rst)
    mem_en && up_req && !is_alias |-> mem_addr == up_addr); // R7

  AST_LOAD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    mem_en && up_req && !up_we |-> !mem_we); // R5

  AST_WRITEBACK_FIRST: assert property (@(posedge clk) disable iff (rst)
    up_ready && up_req && up_we && is_alias |-> $past(mem_we)); // R6

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
    up_ready |=> !up_ready); // R8

endmodule

bind bb_alias_xlate bb_alias_xlate_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/bb_alias_xlate_tb.sv
`timescale 1ns/1ps
module bb_alias_xlate_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        up_req = 1'b0;
  logic        up_we = 1'b0;
  logic [31:0] up_addr = '0;
  logic [31:0] up_wdata = '0;
  logic [31:0] up_rdata;
  logic        up_ready;
  logic        mem_en;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;

  int checks = 0;
  int errors = 0;
  int wr_cnt = 0;

  typedef struct {
    logic        is_rd;
    logic [31:0] exp;
    string       tag;
  } sb_item_t;

  sb_item_t    sbq[$];
  logic [31:0] mem [logic [31:0]];
  logic [31:0] shd [logic [31:0]];

  always #2 clk = ~clk;

  bb_alias_xlate u_dut (
    .clk(clk), .rst(rst), .up_req(up_req), .up_we(up_we), .up_addr(up_addr),
    .up_wdata(up_wdata), .up_rdata(up_rdata), .up_ready(up_ready),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // Synchronous memory model
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[mem_addr] = mem_wdata;
      else mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
    end
  end

  always @(negedge clk) if (!rst && mem_en && mem_we) wr_cnt++;

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && up_ready) begin
      if (sbq.size() == 0) begin
        check(1'b0, "R8 unexpected ready", 32'h1, 32'h0);
      end else begin
        sb_item_t it;
        it = sbq.pop_front();
        if (it.is_rd) check(up_rdata == it.exp, it.tag, up_rdata, it.exp);
      end
    end
  end

  function automatic logic [31:0] shd_rd(input logic [31:0] a);
    return shd.exists(a) ? shd[a] : 32'h0;
  endfunction

  function automatic logic [31:0] alias_of(input logic [31:0] base,
                                           input logic [31:0] off, input int b);
    return (base & 32'hF000_0000) | 32'h0200_0000 |
           ((off & 32'h000F_FFFF) << 5) | (32'(b) << 2);
  endfunction

  task automatic access(input logic we, input logic [31:0] a, input logic [31:0] wd,
                        input logic [31:0] exp, input string tag, input int exp_wr);
    sb_item_t it;
    int t = 0;
    int w0;
    it.is_rd = !we;
    it.exp = exp;
    it.tag = tag;
    sbq.push_back(it);
    @(negedge clk);
    w0 = wr_cnt;
    up_req = 1'b1; up_we = we; up_addr = a; up_wdata = wd;
    @(negedge clk);
    while (!up_ready && t < 100) begin @(negedge clk); t++; end
    check(up_ready == 1'b1, {tag, " R8 ready seen"}, 32'(up_ready), 32'h1);
    check(wr_cnt - w0 == exp_wr, {tag, " R6 write count"}, 32'(wr_cnt - w0), 32'(exp_wr));
    up_req = 1'b0;
    @(negedge clk);
    check(up_ready == 1'b0, {tag, " R8 ready single cycle"}, 32'(up_ready), 32'h0);
  endtask

  task automatic pwrite(input logic [31:0] a, input logic [31:0] d, input string tag);
    shd[a] = d;
    access(1'b1, a, d, 32'h0, tag, 1);
  endtask

  task automatic pread(input logic [31:0] a, input string tag);
    access(1'b0, a, 32'h0, shd_rd(a), tag, 0);
  endtask

  task automatic awrite(input logic [31:0] base, input logic [31:0] off, input int b,
                        input logic [31:0] wd, input string tag);
    logic [31:0] w;
    w = shd_rd(base | off);
    w[b] = wd[0];
    shd[base | off] = w;
    access(1'b1, alias_of(base, off, b), wd, 32'h0, tag, 1);
  endtask

  task automatic aread(input logic [31:0] base, input logic [31:0] off, input int b,
                       input string tag);
    logic [31:0] w;
    w = shd_rd(base | off);
    access(1'b0, alias_of(base, off, b), 32'h0, {31'h0, w[b]}, tag, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R8 watchdog expired actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(up_ready == 1'b0, "R8 reset ready", 32'(up_ready), 32'h0);
    check(mem_en == 1'b0, "R8 reset mem_en", 32'(mem_en), 32'h0);

    // R7 plain stores and loads, including an address outside all regions
    pwrite(32'h2000_0010, 32'hA5A5_0F0F, "R7 plain store A");
    pwrite(32'h4000_0104, 32'h0000_0000, "R7 plain store B");
    pwrite(32'h1000_0000, 32'h1234_5678, "R7 plain store outside");
    pread(32'h2000_0010, "R7 plain load A");
    pread(32'h1000_0000, "R7 plain load outside");

    // R1 near-alias addresses stay plain
    pwrite(32'h2400_0000, 32'hDEAD_BEEF, "R1 bit26 store");
    pwrite(32'h2100_0000, 32'h0BAD_F00D, "R1 bit24 store");
    pread(32'h2400_0000, "R1 bit26 load");
    pread(32'h2100_0000, "R1 bit24 load");

    // R3 set and clear single bits, neighbours kept
    awrite(32'h2000_0000, 32'h10, 4, 32'h1, "R3 set bit4");
    pread(32'h2000_0010, "R3 word after set");
    awrite(32'h2000_0000, 32'h10, 0, 32'h0, "R3 clear bit0");
    pread(32'h2000_0010, "R3 word after clear");

    // R4 only bit 0 of store data matters
    awrite(32'h2000_0000, 32'h10, 1, 32'hFFFF_FFFE, "R4 clear with FFFFFFFE");
    awrite(32'h4000_0000, 32'h104, 31, 32'hFFFF_FFFF, "R4 set with FFFFFFFF");
    awrite(32'h4000_0000, 32'h104, 7, 32'h0000_0002, "R4 data 2 clears");
    pread(32'h2000_0010, "R4 word A");
    pread(32'h4000_0104, "R4 word B");

    // R5 boolean alias loads
    aread(32'h4000_0000, 32'h104, 31, "R5 load bit31 one");
    aread(32'h4000_0000, 32'h104, 30, "R5 load bit30 zero");
    aread(32'h2000_0000, 32'h10, 2, "R5 load bit2 one");
    aread(32'h2000_0000, 32'h10, 4, "R5 load bit4 one");

    // R2 highest alias word maps to bit 31 of the last primary word
    pwrite(32'h400F_FFFC, 32'h0000_0001, "R2 seed last word");
    awrite(32'h4000_0000, 32'hF_FFFC, 31, 32'h1, "R2 top alias store");
    pread(32'h400F_FFFC, "R2 last word");
    aread(32'h4000_0000, 32'hF_FFFC, 31, "R2 top alias load");

    // R6 back-to-back alias stores on the same word
    awrite(32'h2000_0000, 32'h20, 0, 32'h1, "R6 rmw first");
    awrite(32'h2000_0000, 32'h20, 1, 32'h1, "R6 rmw second");
    pread(32'h2000_0020, "R6 word after two rmw");

    repeat (3) @(negedge clk);
    check(sbq.size() == 0, "R8 scoreboard drained", 32'(sbq.size()), 32'h0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule